// File: doc/BRIEF.md
# Byte-Wide Call Stack Controller

This block runs the hardware stack of an 8-bit accumulator-style processor. The stack lives in a 256-byte internal data RAM, and the RAM array sits outside the block. The block holds the stack pointer and exposes it as a special-function register that software can read or load at any time. The block does no bounds checking, so any value may be written.

The processor's control unit raises single-cycle requests to push a byte, pop a byte, save the program counter on a call, or restore it on a return or a return from interrupt. The pointer always addresses the most recently stored byte. A store first advances the pointer and then writes at the new address. A fetch first reads at the current address and then moves the pointer back. The pointer wraps modulo 256.

A program counter is wider than one RAM byte, so it moves in several consecutive stack cycles. A call stores the least significant byte first. A return fetches the most significant byte first. While such a sequence is running the block reports itself busy and ignores every new request.

Top module: `stkc_top`

## Requirements
- R1: After reset the pointer holds 07h, `busy`, `pop_valid`, `ret_valid` and `reti_done` are low, and no RAM write is issued.
- R2: `sfr_rdata` returns the pointer while `sfr_addr` equals 81h and returns 00h for any other address.
- R3: A push drives `ram_we` high, with `ram_addr` equal to the pointer plus one and `ram_wdata` equal to `push_data`, in the cycle of the request. The pointer then holds that address, so the first push after reset writes address 08h.
- R4: A pop drives `ram_addr` to the current pointer. On the next cycle `pop_valid` is high for one cycle, `pop_data` holds the byte read, and the pointer has dropped by one.
- R5: A call writes `call_pc[7:0]` at pointer+1 in the request cycle and `call_pc[15:8]` at pointer+2 in the next cycle. The pointer ends two higher, and `busy` is high during the second cycle.
- R6: A return reads the high byte at the pointer and then the low byte at pointer−1 on the next cycle. One cycle after the second read, `ret_valid` pulses for one cycle with `ret_pc` = {high, low}, and the pointer ends two lower.
- R7: A return from interrupt behaves as R6, and in addition `reti_done` pulses high in the same cycle as `ret_valid`. A plain return leaves `reti_done` low.
- R8: While `busy` is high, push, pop, call and return requests cause no RAM write, no extra pointer movement, and no `pop_valid` or `ret_valid` pulse.
- R9: A write with `sfr_wr` high at address 81h loads `sfr_wdata` into the pointer on the next edge. The load takes precedence over any pointer step in the same cycle. The RAM access of a push or pop in that cycle is still carried out.
- R10: The pointer wraps. A push at FFh writes address 00h and leaves 00h. A pop at 00h leaves FFh.
- R11: When several requests arrive together while idle, only one is taken. Call ranks first, then return from interrupt, then return, then push, then pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr | input | 1 | Special-function register write strobe |
| sfr_wdata | input | 8 | Value written to the pointer |
| sfr_rdata | output | 8 | Pointer value when 81h is addressed, else 00h |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| pop_data | output | 8 | Byte popped |
| pop_valid | output | 1 | One-cycle strobe qualifying `pop_data` |
| call_req | input | 1 | Save the program counter |
| call_pc | input | 16 | Program counter to save |
| ret_req | input | 1 | Restore the program counter |
| reti_req | input | 1 | Restore the program counter, ending an interrupt |
| ret_pc | output | 16 | Restored program counter |
| ret_valid | output | 1 | One-cycle strobe qualifying `ret_pc` |
| reti_done | output | 1 | One-cycle pulse at the end of a return from interrupt |
| busy | output | 1 | Multi-cycle sequence in progress; requests ignored |
| ram_addr | output | 8 | Stack RAM address |
| ram_we | output | 1 | Stack RAM write enable |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_rdata | input | 8 | Stack RAM read data, combinational from `ram_addr` |

## Verification
The bench attacks the byte order of calls and returns. A design that swapped the order would return a program counter with its halves exchanged. It checks the pointer wrap at FFh and 00h, where a pointer that saturated or carried into a wider register would land on the wrong byte. It checks a software load in the same cycle as a push or pop: a design that let the step win would be off by one from the loaded value. Requests held during the second half of a call probe `busy`, since a leaky design would write a stray byte there. Simultaneous requests probe the priority order.

// File: rtl/stkc_pkg.sv
package stkc_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_CALL = 2'd1,
      SQ_RET  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/stkc_ptr.sv
module stkc_ptr #(
   parameter int             AW  = 8,
   parameter logic [AW-1:0]  RST = 8'h07
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] sp
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)     sp <= RST;
      else if (load)  sp <= load_val;
      else if (inc)   sp <= sp + ONE;
      else if (dec)   sp <= sp - ONE;
   end

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (sp == $past(sp) + ONE));                  // R3
   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (sp == $past(sp) - ONE));                  // R4
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sp == $past(load_val)));                            // R9
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));                                               // R11
endmodule

// File: rtl/stkc_seq.sv
module stkc_seq
   import stkc_pkg::*;
#(
   parameter int DW  = 8,
   parameter int AW  = 8,
   parameter int PCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           call_req,
   input  logic           ret_req,
   input  logic           reti_req,
   input  logic           push_req,
   input  logic           pop_req,
   input  logic [DW-1:0]  push_data,
   input  logic [PCW-1:0] call_pc,
   input  logic [AW-1:0]  sp,
   input  logic [DW-1:0]  ram_rdata,
   output logic           inc,
   output logic           dec,
   output logic [AW-1:0]  ram_addr,
   output logic           ram_we,
   output logic [DW-1:0]  ram_wdata,
   output logic [DW-1:0]  pop_data,
   output logic           pop_valid,
   output logic [PCW-1:0] ret_pc,
   output logic           ret_valid,
   output logic           reti_done,
   output logic           busy
);
   localparam int            NB   = PCW / DW;
   localparam int            CW   = (NB > 2) ? $clog2(NB) : 1;
   localparam logic [CW-1:0] LAST = CW'(NB - 1);
   localparam logic [AW-1:0] ONE  = AW'(1);

   seq_state_e     state;
   logic [CW-1:0]  cnt;
   logic [PCW-1:0] pc_sh;
   logic [PCW-1:0] acc;
   logic           is_reti;
   logic           take_call, take_ret, take_push, take_pop;
   logic           last;

   assign last = (cnt == LAST);
   assign busy = (state != SQ_IDLE);

   always_comb begin
      inc       = 1'b0;
      dec       = 1'b0;
      ram_we    = 1'b0;
      ram_wdata = '0;
      ram_addr  = sp;
      take_call = 1'b0;
      take_ret  = 1'b0;
      take_push = 1'b0;
      take_pop  = 1'b0;
      case (state)
         SQ_CALL: begin
            inc       = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = sp + ONE;
            ram_wdata = pc_sh[DW-1:0];
         end
         SQ_RET: dec = 1'b1;
         default: begin
            if (call_req)                 take_call = 1'b1;
            else if (reti_req || ret_req) take_ret  = 1'b1;
            else if (push_req)            take_push = 1'b1;
            else if (pop_req)             take_pop  = 1'b1;
            if (take_call || take_push) begin
               inc       = 1'b1;
               ram_we    = 1'b1;
               ram_addr  = sp + ONE;
               ram_wdata = take_call ? call_pc[DW-1:0] : push_data;
            end
            if (take_ret || take_pop) dec = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cnt       <= '0;
         pc_sh     <= '0;
         acc       <= '0;
         is_reti   <= 1'b0;
         pop_data  <= '0;
         pop_valid <= 1'b0;
         ret_pc    <= '0;
         ret_valid <= 1'b0;
         reti_done <= 1'b0;
      end else begin
         pop_valid <= 1'b0;
         ret_valid <= 1'b0;
         reti_done <= 1'b0;
         case (state)
            SQ_CALL: begin
               pc_sh <= pc_sh >> DW;
               cnt   <= cnt + 1'b1;
               if (last) state <= SQ_IDLE;
            end
            SQ_RET: begin
               acc <= {acc[PCW-DW-1:0], ram_rdata};
               cnt <= cnt + 1'b1;
               if (last) begin
                  state     <= SQ_IDLE;
                  ret_pc    <= {acc[PCW-DW-1:0], ram_rdata};
                  ret_valid <= 1'b1;
                  reti_done <= is_reti;
               end
            end
            default: begin
               if (take_call) begin
                  state <= SQ_CALL;
                  cnt   <= CW'(1);
                  pc_sh <= call_pc >> DW;
               end
               if (take_ret) begin
                  state   <= SQ_RET;
                  cnt     <= CW'(1);
                  acc     <= {{(PCW-DW){1'b0}}, ram_rdata};
                  is_reti <= reti_req;
               end
               if (take_pop) begin
                  pop_data  <= ram_rdata;
                  pop_valid <= 1'b1;
               end
            end
         endcase
      end
   end

   AST_CALL_LO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && call_req) |-> (ram_we && ram_wdata == call_pc[DW-1:0])); // R5
   AST_RET_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> (!busy && $past(busy)));                          // R6
   AST_RETI_WITH_RET: assert property (@(posedge clk) disable iff (!rst_n)
      reti_done |-> ret_valid);                                       // R7
   AST_RETI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      reti_done |=> !reti_done);                                      // R7
   AST_BUSY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !pop_valid);                                           // R8
endmodule

// File: rtl/stkc_top.sv
module stkc_top #(
   parameter int            DW          = 8,
   parameter int            PCW         = 16,
   parameter int            SFRW        = 8,
   parameter logic [7:0]    SP_RESET    = 8'h07,
   parameter logic [SFRW-1:0] SFR_SP_ADDR = 8'h81,
   parameter bit            SFR_RD_REG  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SFRW-1:0] sfr_addr,
   input  logic            sfr_wr,
   input  logic [DW-1:0]   sfr_wdata,
   output logic [DW-1:0]   sfr_rdata,
   input  logic            push_req,
   input  logic [DW-1:0]   push_data,
   input  logic            pop_req,
   output logic [DW-1:0]   pop_data,
   output logic            pop_valid,
   input  logic            call_req,
   input  logic [PCW-1:0]  call_pc,
   input  logic            ret_req,
   input  logic            reti_req,
   output logic [PCW-1:0]  ret_pc,
   output logic            ret_valid,
   output logic            reti_done,
   output logic            busy,
   output logic [DW-1:0]   ram_addr,
   output logic            ram_we,
   output logic [DW-1:0]   ram_wdata,
   input  logic [DW-1:0]   ram_rdata
);
   localparam int AW = DW;

   initial begin
      if ((PCW % DW) != 0 || (PCW / DW) < 2)
         $fatal(1, "stkc_top: PCW must be a multiple of DW of at least two bytes");
      if (DW < 2)
         $fatal(1, "stkc_top: DW too small");
   end

   logic [AW-1:0] sp;
   logic          inc, dec, sp_sel, load;

   assign sp_sel = (sfr_addr == SFR_SP_ADDR);
   assign load   = sfr_wr && sp_sel;

   stkc_ptr #(.AW(AW), .RST(AW'(SP_RESET))) u_ptr (
      .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
      .load(load), .load_val(sfr_wdata), .sp(sp)
   );

   stkc_seq #(.DW(DW), .AW(AW), .PCW(PCW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .call_req(call_req), .ret_req(ret_req), .reti_req(reti_req),
      .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
      .call_pc(call_pc), .sp(sp), .ram_rdata(ram_rdata),
      .inc(inc), .dec(dec), .ram_addr(ram_addr), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .pop_data(pop_data), .pop_valid(pop_valid),
      .ret_pc(ret_pc), .ret_valid(ret_valid), .reti_done(reti_done),
      .busy(busy)
   );

   generate
      if (SFR_RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) sfr_rdata <= '0;
            else        sfr_rdata <= sp_sel ? sp : '0;
         end
      end else begin : g_rd_comb
         assign sfr_rdata = sp_sel ? sp : '0;
      end
   endgenerate

   AST_RESET_PTR: assert property (@(posedge clk)
      !rst_n |=> (!busy && !ram_we && !pop_valid && !ret_valid));     // R1
   AST_WRAP_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && sp == '1) |-> (ram_addr == '0));                     // R10
endmodule

// File: tb/tb_stkc_top.sv
`timescale 1ns/1ps
module tb_stkc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = 8'h81;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic [7:0]  sfr_rdata;
   logic        push_req = 1'b0;
   logic [7:0]  push_data = '0;
   logic        pop_req = 1'b0;
   logic [7:0]  pop_data;
   logic        pop_valid;
   logic        call_req = 1'b0;
   logic [15:0] call_pc = '0;
   logic        ret_req = 1'b0;
   logic        reti_req = 1'b0;
   logic [15:0] ret_pc;
   logic        ret_valid, reti_done, busy;
   logic [7:0]  ram_addr, ram_wdata, ram_rdata;
   logic        ram_we;

   logic [7:0]  mem [256];
   int          mref [256];

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int m_sp = 7, m_seq = 0, m_hi = 0, m_acc = 0, m_reti = 0;
   int e_pv = 0, e_pd = 0, e_rv = 0, e_rpc = 0, e_rd = 0;

   always #2.5 clk = ~clk;

   stkc_top dut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .push_req(push_req),
      .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
      .pop_valid(pop_valid), .call_req(call_req), .call_pc(call_pc),
      .ret_req(ret_req), .reti_req(reti_req), .ret_pc(ret_pc),
      .ret_valid(ret_valid), .reti_done(reti_done), .busy(busy),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata)
   );

   assign ram_rdata = mem[ram_addr];
   always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit c, input bit r, input bit ri,
                       input bit pu, input bit po, input int pd, input int pc,
                       input bit sw, input int sa, input int swd);
      int nsp, x_we, x_addr, x_wd, x_rdop, n_pv, n_pd, n_rv, n_rpc, n_rd, x_busy, x_sfr;
      call_req = c; ret_req = r; reti_req = ri; push_req = pu; pop_req = po;
      push_data = 8'(pd); call_pc = 16'(pc); sfr_wr = sw;
      sfr_addr = 8'(sa); sfr_wdata = 8'(swd);
      #1;
      nsp = m_sp; x_we = 0; x_addr = m_sp; x_wd = 0; x_rdop = 0;
      n_pv = 0; n_pd = e_pd; n_rv = 0; n_rpc = e_rpc; n_rd = 0;
      x_busy = (m_seq != 0) ? 1 : 0;
      x_sfr  = (sa == 'h81) ? m_sp : 0;
      if (m_seq == 1) begin
         x_we = 1; x_addr = (m_sp + 1) & 255; x_wd = m_hi; nsp = x_addr; m_seq = 0;
      end else if (m_seq == 2) begin
         x_rdop = 1; n_rv = 1; n_rpc = (m_acc << 8) | mref[m_sp]; n_rd = m_reti;
         nsp = (m_sp - 1) & 255; m_seq = 0;
      end else if (c) begin
         x_we = 1; x_addr = (m_sp + 1) & 255; x_wd = pc & 255; nsp = x_addr;
         m_hi = (pc >> 8) & 255; m_seq = 1;
      end else if (ri || r) begin
         x_rdop = 1; m_acc = mref[m_sp]; m_reti = ri ? 1 : 0;
         nsp = (m_sp - 1) & 255; m_seq = 2;
      end else if (pu) begin
         x_we = 1; x_addr = (m_sp + 1) & 255; x_wd = pd & 255; nsp = x_addr;
      end else if (po) begin
         x_rdop = 1; n_pv = 1; n_pd = mref[m_sp]; nsp = (m_sp - 1) & 255;
      end
      if (sw && sa == 'h81) nsp = swd & 255;
      if (x_we != 0) mref[x_addr] = x_wd;

      chk(tag, "ram_we", int'(ram_we), x_we);
      if (x_we != 0 || x_rdop != 0) chk(tag, "ram_addr", int'(ram_addr), x_addr);
      if (x_we != 0) chk(tag, "ram_wdata", int'(ram_wdata), x_wd);
      chk(tag, "busy", int'(busy), x_busy);
      chk(tag, "sfr_rdata", int'(sfr_rdata), x_sfr);
      chk(tag, "pop_valid", int'(pop_valid), e_pv);
      if (e_pv != 0) chk(tag, "pop_data", int'(pop_data), e_pd);
      chk(tag, "ret_valid", int'(ret_valid), e_rv);
      if (e_rv != 0) chk(tag, "ret_pc", int'(ret_pc), e_rpc);
      chk(tag, "reti_done", int'(reti_done), e_rd);

      e_pv = n_pv; e_pd = n_pd; e_rv = n_rv; e_rpc = n_rpc; e_rd = n_rd;
      m_sp = nsp;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int sa);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 0, sa, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]  = 8'((i * 7 + 3) & 255);
         mref[i] = (i * 7 + 3) & 255;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      idle("R1", 'h81);
      // pushes, first one at 08h
      step("R3", 0, 0, 0, 1, 0, 'hAA, 0, 0, 'h81, 0);
      step("R3", 0, 0, 0, 1, 0, 'hBB, 0, 0, 'h81, 0);
      step("R3", 0, 0, 0, 1, 0, 'hCC, 0, 0, 'h81, 0);
      // register read decode
      idle("R2", 'h80);
      idle("R2", 'h81);
      // pops
      step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 'h81, 0);
      step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 'h81, 0);
      idle("R4", 'h81);
      // call
      step("R5", 1, 0, 0, 0, 0, 0, 'h1234, 0, 'h81, 0);
      idle("R5", 'h81);
      // call with requests held during the busy cycle
      step("R8", 1, 0, 0, 0, 0, 0, 'h5678, 0, 'h81, 0);
      step("R8", 1, 1, 0, 1, 1, 'h99, 'h4321, 0, 'h81, 0);
      idle("R8", 'h81);
      // plain return
      step("R6", 0, 1, 0, 0, 0, 0, 0, 0, 'h81, 0);
      idle("R6", 'h81);
      idle("R6", 'h81);
      // return from interrupt
      step("R7", 0, 0, 1, 0, 0, 0, 0, 0, 'h81, 0);
      idle("R7", 'h81);
      idle("R7", 'h81);
      // software load against push and pop
      step("R9", 0, 0, 0, 1, 0, 'h11, 0, 1, 'h81, 'h40);
      step("R9", 0, 0, 0, 0, 1, 0, 0, 1, 'h81, 'h50);
      idle("R9", 'h81);
      step("R9", 0, 0, 0, 1, 0, 'h22, 0, 1, 'h82, 'h33);
      idle("R9", 'h81);
      // wrap
      step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 'h81, 'hFF);
      step("R10", 0, 0, 0, 1, 0, 'h5A, 0, 0, 'h81, 0);
      step("R10", 0, 0, 0, 0, 1, 0, 0, 0, 'h81, 0);
      idle("R10", 'h81);
      step("R10", 0, 0, 0, 1, 0, 'h6B, 0, 0, 'h81, 0);
      step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 'h81, 'h00);
      step("R10", 0, 0, 0, 0, 1, 0, 0, 0, 'h81, 0);
      idle("R10", 'h81);
      // priority
      step("R11", 1, 1, 1, 1, 1, 'h77, 'hBEEF, 0, 'h81, 0);
      idle("R11", 'h81);
      step("R11", 0, 1, 1, 1, 1, 'h77, 0, 0, 'h81, 0);
      idle("R11", 'h81);
      idle("R11", 'h81);
      step("R11", 0, 0, 0, 1, 1, 'h3C, 0, 0, 'h81, 0);
      step("R11", 0, 0, 0, 0, 1, 0, 0, 0, 'h81, 0);
      idle("R11", 'h81);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule